// File: doc/BRIEF.md
# Instruction cycle-count timing unit

This block models how many clock cycles each instruction of a small 8-bit accumulator CPU takes. It receives one pre-decoded descriptor per instruction: an addressing-mode code, an operation-class code, a flag saying a conditional branch was taken, and a flag saying the taken target lies in another 256-byte page. The cycle cost is not read from a per-opcode table. It is built by adding rules: a base of two cycles, a cost for the addressing mode, a cost for the operation class, an extra cycle for read-modify-write (RMW) accesses, and branch penalties.

The cost is loaded into a down-counter once the descriptor is accepted. The block raises a one-clock `done` strobe on the last cycle of the instruction. It also adds every accepted cost to a 32-bit running total. A descriptor is accepted on a valid/ready handshake. Ready is asserted during the last cycle of an instruction, so instructions can follow one another with no idle cycle between them. Undefined codes fall back to the two-cycle base cost and set a sticky error flag.

Top module: `instr_cycle_timer`

## Requirements
- R1: The cost is 2 plus a mode adder. Mode codes and adders are: implied/accumulator 0 (+0), immediate 1 (+0), zero page 2 (+1), zero page indexed 3 (+2), absolute 4 (+2), absolute,X 5 (+2), absolute,Y 6 (+2), indirect jump 7 (+4), pre-indexed indirect 8 (+4), post-indexed indirect 9 (+3), relative 10 (+0).
- R2: One extra cycle is added for RMW accesses. These are mode 5 with op class store (1), shift/rotate (2) or increment/decrement (3), and modes 6 or 9 with op class store (1). Op classes 0 (plain ALU/load) and 1 (store) otherwise add nothing.
- R3: Op class 2 (shift/rotate) adds 2 cycles unless the mode is 0, in which case it adds nothing. Op class 3 (increment/decrement memory) adds 2 cycles.
- R4: Control-flow op classes adjust the cost as follows: 4 (jump) subtracts 1, 5 (subroutine call) adds 2, 6 (subroutine return) adds 4, 7 (interrupt return) adds 4, 8 (break) adds 5.
- R5: Op class 9 (stack push) adds 1 cycle. Op class 10 (stack pull) adds 2 cycles.
- R6: Op class 11 (conditional branch) adds 1 when `in_taken` is high, plus 1 more when `in_page_cross` is also high. `in_page_cross` has no effect on a branch that is not taken.
- R7: A descriptor is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no instruction is running or the running one is in its final cycle.
- R8: After acceptance, `done` is high for exactly one clock, on the N-th cycle, where N is the cost.
- R9: `total_cycles` increases by the cost in the cycle after each acceptance.
- R10: A mode code of 11 to 15 or an op class of 12 to 15 gives a cost of exactly 2 and sets `err_flag`, which stays high until reset.
- R11: A synchronous reset clears the total, the down-counter and the error flag, leaving `in_ready` high and `done` low.
- R12: While `in_valid` is low, the descriptor inputs have no effect: the total does not move and no `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor present |
| in_mode | input | 4 | Addressing-mode code |
| in_op | input | 4 | Operation-class code |
| in_taken | input | 1 | Conditional branch taken |
| in_page_cross | input | 1 | Taken branch target is in another page |
| in_ready | output | 1 | Block can accept a descriptor this cycle |
| done | output | 1 | Final cycle of the current instruction |
| total_cycles | output | 32 | Running sum of accepted costs |
| err_flag | output | 1 | Sticky flag for undefined codes |

## Verification
The assertions check the following on every cycle:
- the total grows by exactly the accepted cost and stays put otherwise;
- the error flag never falls;
- `done` always coincides with `in_ready`;
- a loaded counter holds the cost;
- `done` never lasts two cycles unless a new descriptor is taken;
- every accepted cost lies between 1 and 11.

Whether each cost is correct for each mode and class combination can only be shown by the bench scenarios. The same holds for the branch and RMW penalties, for the spacing of `done` over back-to-back instructions, and for the clearing done by reset. The bench compares these against costs it computes independently.

// File: rtl/ict_pkg.sv
package ict_pkg;
    // addressing-mode codes
    localparam logic [3:0] M_IMP = 4'd0;
    localparam logic [3:0] M_IMM = 4'd1;
    localparam logic [3:0] M_ZPG = 4'd2;
    localparam logic [3:0] M_ZPX = 4'd3;
    localparam logic [3:0] M_ABS = 4'd4;
    localparam logic [3:0] M_ABX = 4'd5;
    localparam logic [3:0] M_ABY = 4'd6;
    localparam logic [3:0] M_IND = 4'd7;
    localparam logic [3:0] M_IZX = 4'd8;
    localparam logic [3:0] M_IZY = 4'd9;
    localparam logic [3:0] M_REL = 4'd10;
    // operation-class codes
    localparam logic [3:0] O_ALU = 4'd0;
    localparam logic [3:0] O_STO = 4'd1;
    localparam logic [3:0] O_SHF = 4'd2;
    localparam logic [3:0] O_IDC = 4'd3;
    localparam logic [3:0] O_JMP = 4'd4;
    localparam logic [3:0] O_JSR = 4'd5;
    localparam logic [3:0] O_RTS = 4'd6;
    localparam logic [3:0] O_RTI = 4'd7;
    localparam logic [3:0] O_BRK = 4'd8;
    localparam logic [3:0] O_PSH = 4'd9;
    localparam logic [3:0] O_PUL = 4'd10;
    localparam logic [3:0] O_BRA = 4'd11;

    localparam int BASE_COST = 2;
    localparam int MAX_COST  = 11;
endpackage

// File: rtl/ict_mode_cost.sv
module ict_mode_cost
    import ict_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [3:0]    mode_i,
    input  logic [3:0]    op_i,
    output logic [CW-1:0] add_o,
    output logic          bad_o
);
    logic [CW-1:0] mode_add;
    logic          mem_op;
    logic          rmw;

    always_comb begin
        bad_o    = 1'b0;
        mode_add = '0;
        case (mode_i)
            M_IMP, M_IMM, M_REL:  mode_add = CW'(0);
            M_ZPG:                mode_add = CW'(1);
            M_ZPX:                mode_add = CW'(2);
            M_ABS, M_ABX, M_ABY:  mode_add = CW'(2);
            M_IND, M_IZX:         mode_add = CW'(4);
            M_IZY:                mode_add = CW'(3);
            default:              bad_o    = 1'b1;
        endcase
    end

    // memory-writing classes that pay the indexed penalty
    assign mem_op = (op_i == O_STO) || (op_i == O_SHF) || (op_i == O_IDC);
    assign rmw    = ((mode_i == M_ABX) && mem_op) ||
                    (((mode_i == M_ABY) || (mode_i == M_IZY)) && (op_i == O_STO));
    assign add_o  = mode_add + CW'(rmw);
endmodule

// File: rtl/ict_op_cost.sv
module ict_op_cost
    import ict_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [3:0]    op_i,
    input  logic [3:0]    mode_i,
    input  logic          taken_i,
    input  logic          page_i,
    output logic [CW-1:0] base_o,
    output logic          bad_o
);
    localparam logic [CW-1:0] B = CW'(BASE_COST);

    always_comb begin
        bad_o  = 1'b0;
        base_o = B;
        case (op_i)
            O_ALU, O_STO: base_o = B;
            O_SHF:        base_o = (mode_i == M_IMP) ? B : B + CW'(2);
            O_IDC:        base_o = B + CW'(2);
            O_JMP:        base_o = B - CW'(1);
            O_JSR:        base_o = B + CW'(2);
            O_RTS, O_RTI: base_o = B + CW'(4);
            O_BRK:        base_o = B + CW'(5);
            O_PSH:        base_o = B + CW'(1);
            O_PUL:        base_o = B + CW'(2);
            O_BRA:        base_o = B + CW'(taken_i) + CW'(taken_i & page_i);
            default:      bad_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/ict_seq.sv
module ict_seq #(
    parameter int CW = 4,
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept_i,
    input  logic [CW-1:0] cost_i,
    input  logic          bad_i,
    output logic          ready_o,
    output logic          done_o,
    output logic [TW-1:0] total_o,
    output logic          err_o
);
    typedef struct packed {
        logic [CW-1:0] rem;
        logic [TW-1:0] total;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rem != '0)
            st_d.rem = st_q.rem - CW'(1);
        if (accept_i) begin
            st_d.rem   = cost_i;
            st_d.total = st_q.total + TW'(cost_i);
            if (bad_i)
                st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ready_o = (st_q.rem <= CW'(1));
    assign done_o  = (st_q.rem == CW'(1));
    assign total_o = st_q.total;
    assign err_o   = st_q.err;

    // R9
    total_add_chk: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> total_o == $past(total_o) + TW'($past(cost_i)));
    // R12
    total_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(total_o));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    // R7
    ready_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ready_o);
    // R8
    load_cost_chk: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> st_q.rem == $past(cost_i));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !accept_i) |=> !done_o);
endmodule

// File: rtl/instr_cycle_timer.sv
module instr_cycle_timer
    import ict_pkg::*;
#(
    parameter int CW = 4,
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    in_mode,
    input  logic [3:0]    in_op,
    input  logic          in_taken,
    input  logic          in_page_cross,
    output logic          in_ready,
    output logic          done,
    output logic [TW-1:0] total_cycles,
    output logic          err_flag
);
    logic [CW-1:0] mode_add, op_base, cost;
    logic          mode_bad, op_bad, bad, accept;

    ict_mode_cost #(.CW(CW)) u_mode (
        .mode_i (in_mode),
        .op_i   (in_op),
        .add_o  (mode_add),
        .bad_o  (mode_bad)
    );

    ict_op_cost #(.CW(CW)) u_op (
        .op_i    (in_op),
        .mode_i  (in_mode),
        .taken_i (in_taken),
        .page_i  (in_page_cross),
        .base_o  (op_base),
        .bad_o   (op_bad)
    );

    assign bad    = mode_bad | op_bad;
    assign cost   = bad ? CW'(BASE_COST) : op_base + mode_add;
    assign accept = in_valid & in_ready;

    ict_seq #(.CW(CW), .TW(TW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .cost_i   (cost),
        .bad_i    (bad),
        .ready_o  (in_ready),
        .done_o   (done),
        .total_o  (total_cycles),
        .err_o    (err_flag)
    );

    // R1
    cost_bound_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (cost >= CW'(1)) && (cost <= CW'(MAX_COST)));
    // R10
    bad_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && bad) |=> err_flag);
endmodule

// File: tb/sim_instr_cycle_timer.sv
module sim_instr_cycle_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_mode = '0;
    logic [3:0]  in_op = '0;
    logic        in_taken = 1'b0;
    logic        in_page_cross = 1'b0;
    logic        in_ready, done, err_flag;
    logic [31:0] total_cycles;

    int n_chk = 0;
    int n_bad = 0;
    longint exp_total = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    instr_cycle_timer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_op(in_op), .in_taken(in_taken), .in_page_cross(in_page_cross),
        .in_ready(in_ready), .done(done), .total_cycles(total_cycles),
        .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected cost computed from the requirement text
    function automatic int exp_cost(input int m, input int o, input bit t, input bit p);
        int c;
        bit rmw;
        if (m > 10 || o > 11) return 2;
        c = 2;
        if (m == 2) c += 1;
        else if (m == 3 || m == 4 || m == 5 || m == 6) c += 2;
        else if (m == 7 || m == 8) c += 4;
        else if (m == 9) c += 3;
        rmw = (m == 5 && (o == 1 || o == 2 || o == 3)) || ((m == 6 || m == 9) && o == 1);
        if (rmw) c += 1;
        case (o)
            2: if (m != 0) c += 2;
            3: c += 2;
            4: c -= 1;
            5: c += 2;
            6, 7: c += 4;
            8: c += 5;
            9: c += 1;
            10: c += 2;
            11: if (t) c += (p ? 2 : 1);
            default: ;
        endcase
        return c;
    endfunction

    // issue one descriptor while idle, measure its latency to done
    task automatic run_one(input int m, input int o, input bit t, input bit p, input string tag);
        int n, e;
        e = exp_cost(m, o, t, p);
        @(negedge clk);
        in_mode = 4'(m); in_op = 4'(o); in_taken = t; in_page_cross = p;
        in_valid = 1'b1;
        chk(in_ready, "R7 ready before issue", in_ready, 1);
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            in_valid = 1'b0;
            n++;
        end while (!done && n < 20);
        exp_total += e;
        chk(n == e, {tag, " latency"}, n, e);
        chk(total_cycles == 32'(exp_total), "R9 total", total_cycles, exp_total);
        chk(in_ready, "R7 ready on final cycle", in_ready, 1);
        @(negedge clk);
        chk(!done, "R8 done single pulse", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(total_cycles == 0, "R11 total", total_cycles, 0);
        chk(!err_flag, "R11 err", err_flag, 0);
        chk(in_ready, "R11 ready", in_ready, 1);
        chk(!done, "R11 done", done, 0);

        // R1 directed mode adders
        run_one(0, 0, 0, 0, "R1 implied");
        run_one(1, 0, 0, 0, "R1 immediate");
        run_one(2, 0, 0, 0, "R1 zero page");
        run_one(3, 0, 0, 0, "R1 zp indexed");
        run_one(4, 0, 0, 0, "R1 absolute");
        run_one(8, 0, 0, 0, "R1 pre-indexed");
        run_one(9, 0, 0, 0, "R1 post-indexed");
        // R2 RMW
        run_one(5, 1, 0, 0, "R2 store abs,X");
        run_one(6, 1, 0, 0, "R2 store abs,Y");
        run_one(9, 1, 0, 0, "R2 store post-indexed");
        run_one(5, 3, 0, 0, "R2 incdec abs,X");
        run_one(5, 0, 0, 0, "R2 load abs,X no penalty");
        // R3
        run_one(0, 2, 0, 0, "R3 shift accumulator");
        run_one(5, 2, 0, 0, "R3 shift abs,X");
        run_one(2, 3, 0, 0, "R3 incdec zp");
        // R4
        run_one(4, 4, 0, 0, "R4 jump abs");
        run_one(7, 4, 0, 0, "R4 jump indirect");
        run_one(0, 4, 0, 0, "R4 jump cost one");
        run_one(4, 5, 0, 0, "R4 call");
        run_one(0, 6, 0, 0, "R4 return");
        run_one(0, 7, 0, 0, "R4 int return");
        run_one(0, 8, 0, 0, "R4 break");
        // R5
        run_one(0, 9, 0, 0, "R5 push");
        run_one(0, 10, 0, 0, "R5 pull");
        // R6
        run_one(10, 11, 0, 0, "R6 not taken");
        run_one(10, 11, 0, 1, "R6 not taken page ignored");
        run_one(10, 11, 1, 0, "R6 taken");
        run_one(10, 11, 1, 1, "R6 taken page cross");

        // R12 inputs ignored while in_valid low
        @(negedge clk);
        in_mode = 4'd5; in_op = 4'd8; in_taken = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!done, "R12 no done", done, 0);
        end
        chk(total_cycles == 32'(exp_total), "R12 total held", total_cycles, exp_total);

        // R10 undefined codes
        chk(!err_flag, "R10 err clear before", err_flag, 0);
        run_one(12, 0, 0, 0, "R10 bad mode");
        chk(err_flag, "R10 err set", err_flag, 1);
        run_one(4, 14, 0, 0, "R10 bad op");
        run_one(0, 0, 0, 0, "R10 good after bad");
        chk(err_flag, "R10 err sticky", err_flag, 1);

        // R7 R8 back to back: costs 3, 2, 7
        begin
            int ms[3] = '{4, 0, 0};
            int os[3] = '{4, 0, 8};
            int idx, nc, nd, e;
            e = exp_cost(4, 4, 0, 0) + exp_cost(0, 0, 0, 0) + exp_cost(0, 8, 0, 0);
            @(negedge clk);
            in_mode = 4'(ms[0]); in_op = 4'(os[0]); in_taken = 0; in_page_cross = 0;
            in_valid = 1'b1;
            @(posedge clk);
            idx = 1; nc = 0; nd = 0;
            while (nd < 3 && nc < 40) begin
                @(negedge clk);
                nc++;
                if (done) begin
                    nd++;
                    chk(in_ready, "R7 ready with done", in_ready, 1);
                end
                if (in_ready) begin
                    if (idx < 3) begin
                        in_mode = 4'(ms[idx]); in_op = 4'(os[idx]);
                        idx++;
                    end else in_valid = 1'b0;
                end
            end
            in_valid = 1'b0;
            exp_total += e;
            chk(nc == e, "R7 back-to-back no gap", nc, e);
            chk(total_cycles == 32'(exp_total), "R9 total b2b", total_cycles, exp_total);
        end

        // random mix, fixed seed
        void'($urandom(32'd1234));
        for (int k = 0; k < 300; k++) begin
            int m, o;
            m = $urandom_range(0, 10);
            o = $urandom_range(0, 11);
            run_one(m, o, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8 random");
        end

        // R11 reset clears
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(total_cycles == 0, "R11 total after reset", total_cycles, 0);
        chk(!err_flag, "R11 err after reset", err_flag, 0);
        chk(in_ready, "R11 ready after reset", in_ready, 1);
        exp_total = 0;
        run_one(4, 5, 0, 0, "R9 after reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule